// File: doc/BRIEF.md
# Trimmed Real-Time Seconds Counter

This block keeps wall-clock time as a 32-bit count of seconds. It is fed by an oscillator strobe (`osc_tick`, one pulse per oscillator edge as seen in the system clock domain). That strobe is used either directly as a 32.768 kHz reference or, for a 4.194304 MHz source, divided by 128 to reach the same reference rate. A reloading down-counter turns reference ticks into a one-per-second expiry, and each expiry advances the seconds counter.

Fine rate correction comes from a software trim value. The predivider runs a 64-second schedule. Sixty-three seconds reload from the fixed nominal count. The last second of each schedule reloads from the trim value instead, so raising the trim stretches that second and slows the clock, and lowering it speeds the clock up. Software can load a new seconds value at any time. Two independent 32-bit match registers raise sticky flags when the counter reaches them, and software clears each flag by writing a 1 to its bit.

Top module: `rtc_seconds_trim`

## Requirements
- R1: While `ref_en` is 0 no reference tick is produced: `sec_tick_o` stays 0 and `seconds_o` holds, apart from loads.
- R2: With `slow_sel` = 1 every `osc_tick` pulse is one reference tick. With `slow_sel` = 0 one reference tick is produced per `FAST_DIV` pulses (default 128). A counter load resets the phase of that divider.
- R3: The predivider counts reference ticks downward from its reload value and expires at zero, so a nominal second lasts `NOMINAL`+1 reference ticks (default reload 0x7FFF, giving 32768 ticks).
- R4: `trim_o` resets to `NOMINAL` and shows the last value written with `trim_we` on the next cycle. A 6-bit second-of-schedule index starts at 0 after reset. The second whose index is 63 lasts trim+1 reference ticks, and the index then wraps to 0. After reset, the 64th second is therefore the first trimmed one.
- R5: `seconds_o` rises by exactly one on each predivider expiry, one cycle after `sec_tick_o` is high. Neither the predivider nor the counter moves while `rtc_en` is 0.
- R6: A `load_we` pulse places `load_val` on `seconds_o` on the next cycle, takes priority over a same-cycle expiry, and restarts the predivider from the current second's reload value. The next increment therefore comes one full second later.
- R7: The counter wraps from 0xFFFFFFFF to 0.
- R8: Flag bit i of `match_flag_o` is set on the cycle `seconds_o` changes to a value equal to match register i. It stays set until a cycle with `flag_clr[i]` = 1 clears it, and a new match in that same cycle wins over the clear.
- R9: The two match registers are written independently: `match_we[i]` stores `match_val` into register i only. Bit 0 belongs to match register 0, and bit 1 to match register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per oscillator edge |
| ref_en | input | 1 | Reference clock enable |
| slow_sel | input | 1 | 1: strobe is the reference; 0: strobe divided by FAST_DIV |
| rtc_en | input | 1 | Counter and predivider run enable |
| load_we | input | 1 | Load `load_val` into the seconds counter |
| load_val | input | CNT_W | Counter load value |
| trim_we | input | 1 | Write the trim register |
| trim_val | input | TRIM_W | Trim write value |
| match_we | input | N_MATCH | Per-register match write strobes |
| match_val | input | CNT_W | Match write value |
| flag_clr | input | N_MATCH | Write-1-to-clear for the match flags |
| seconds_o | output | CNT_W | Seconds counter |
| trim_o | output | TRIM_W | Current trim register |
| match_flag_o | output | N_MATCH | Sticky match flags |
| sec_tick_o | output | 1 | High in the cycle a second expires |

## Verification
On every cycle the assertions check several relations: a gated reference never produces a second tick, a stopped counter holds, each tick adds exactly one with wrap, a load or trim write lands on the next cycle, and a flag drops only when a clear is written. The length of a second in reference ticks, the placement of the trimmed second on the 64-second schedule, the divide-by-FAST_DIV path, and the exact cycle on which match flags rise are only visible over long windows. These are shown by the bench's timed scenarios.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int unsigned DEF_CNT_W       = 32;
    localparam int unsigned DEF_TRIM_W      = 16;
    localparam int unsigned DEF_FAST_DIV    = 128;
    localparam int unsigned DEF_PERIOD_LOG2 = 6;
    localparam int unsigned DEF_N_MATCH     = 2;
    localparam logic [15:0] DEF_NOMINAL     = 16'h7FFF;
endpackage

// File: rtl/rtc_ref_div.sv
module rtc_ref_div #(
    parameter int unsigned FAST_DIV = rtc_pkg::DEF_FAST_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic clk_en,
    input  logic slow_sel,
    input  logic restart,
    output logic ref_tick
);
    localparam int unsigned DW = (FAST_DIV > 2) ? $clog2(FAST_DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(FAST_DIV - 1);

    typedef struct packed {
        logic [DW-1:0] phase;
    } div_s;

    div_s s_d, s_q;
    logic at_last;

    always_comb begin
        s_d      = s_q;
        at_last  = (s_q.phase == LAST);
        ref_tick = clk_en & osc_tick & (slow_sel | at_last);
        if (restart) begin
            s_d.phase = '0;                                  // R2 phase restart
        end else if (clk_en && osc_tick && !slow_sel) begin
            s_d.phase = at_last ? '0 : s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/rtc_prediv.sv
module rtc_prediv #(
    parameter int unsigned        TRIM_W      = rtc_pkg::DEF_TRIM_W,
    parameter logic [TRIM_W-1:0]  NOMINAL     = TRIM_W'(rtc_pkg::DEF_NOMINAL),
    parameter int unsigned        PERIOD_LOG2 = rtc_pkg::DEF_PERIOD_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              run,
    input  logic              restart,
    input  logic [TRIM_W-1:0] trim,
    output logic              expire
);
    localparam logic [PERIOD_LOG2-1:0] PER_LAST = '1;

    typedef struct packed {
        logic [TRIM_W-1:0]      remain;
        logic [PERIOD_LOG2-1:0] slot;
    } pre_s;

    pre_s s_d, s_q;
    logic [PERIOD_LOG2-1:0] slot_next;

    always_comb begin
        s_d       = s_q;
        slot_next = s_q.slot + 1'b1;
        expire    = run & ref_tick & (s_q.remain == '0) & ~restart;
        if (restart) begin
            // R6: restart the current second from its own reload value
            s_d.remain = (s_q.slot == PER_LAST) ? trim : NOMINAL;
        end else if (run && ref_tick) begin
            if (s_q.remain == '0) begin
                // R4: the final slot of the schedule reloads from trim
                s_d.slot   = slot_next;
                s_d.remain = (slot_next == PER_LAST) ? trim : NOMINAL;
            end else begin
                s_d.remain = s_q.remain - 1'b1;              // R3
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.remain <= NOMINAL;
            s_q.slot   <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/rtc_match.sv
module rtc_match #(
    parameter int unsigned CNT_W = rtc_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             cnt_chg,
    input  logic             clr,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] target;
        logic             hit;
    } cmp_s;

    cmp_s s_d, s_q;
    logic arrive;

    always_comb begin
        s_d    = s_q;
        arrive = cnt_chg & (cnt_next == s_q.target);
        if (wr_en) s_d.target = wr_val;                      // R9
        s_d.hit = arrive | (s_q.hit & ~clr);                 // R8 set wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.hit;
endmodule

// File: rtl/rtc_seconds_trim.sv
module rtc_seconds_trim #(
    parameter int unsigned       CNT_W       = rtc_pkg::DEF_CNT_W,
    parameter int unsigned       TRIM_W      = rtc_pkg::DEF_TRIM_W,
    parameter logic [TRIM_W-1:0] NOMINAL     = TRIM_W'(rtc_pkg::DEF_NOMINAL),
    parameter int unsigned       FAST_DIV    = rtc_pkg::DEF_FAST_DIV,
    parameter int unsigned       PERIOD_LOG2 = rtc_pkg::DEF_PERIOD_LOG2,
    parameter int unsigned       N_MATCH     = rtc_pkg::DEF_N_MATCH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_tick,
    input  logic               ref_en,
    input  logic               slow_sel,
    input  logic               rtc_en,
    input  logic               load_we,
    input  logic [CNT_W-1:0]   load_val,
    input  logic               trim_we,
    input  logic [TRIM_W-1:0]  trim_val,
    input  logic [N_MATCH-1:0] match_we,
    input  logic [CNT_W-1:0]   match_val,
    input  logic [N_MATCH-1:0] flag_clr,
    output logic [CNT_W-1:0]   seconds_o,
    output logic [TRIM_W-1:0]  trim_o,
    output logic [N_MATCH-1:0] match_flag_o,
    output logic               sec_tick_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [TRIM_W-1:0] trim;
    } top_s;

    top_s s_d, s_q;
    logic ref_tick;
    logic expire;
    logic cnt_chg;

    rtc_ref_div #(.FAST_DIV(FAST_DIV)) u_ref_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .clk_en   (ref_en),
        .slow_sel (slow_sel),
        .restart  (load_we),
        .ref_tick (ref_tick)
    );

    rtc_prediv #(
        .TRIM_W      (TRIM_W),
        .NOMINAL     (NOMINAL),
        .PERIOD_LOG2 (PERIOD_LOG2)
    ) u_prediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .run      (rtc_en),
        .restart  (load_we),
        .trim     (s_q.trim),
        .expire   (expire)
    );

    always_comb begin
        s_d = s_q;
        if (trim_we) s_d.trim = trim_val;                    // R4
        if (load_we) begin
            s_d.count = load_val;                            // R6
        end else if (expire) begin
            s_d.count = s_q.count + 1'b1;                    // R5, R7 wrap
        end
        cnt_chg = (s_d.count != s_q.count);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count <= '0;
            s_q.trim  <= NOMINAL;
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_match
        rtc_match #(.CNT_W(CNT_W)) u_match (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (match_we[gi]),
            .wr_val   (match_val),
            .cnt_next (s_d.count),
            .cnt_chg  (cnt_chg),
            .clr      (flag_clr[gi]),
            .flag     (match_flag_o[gi])
        );
    end

    assign seconds_o  = s_q.count;
    assign trim_o     = s_q.trim;
    assign sec_tick_o = expire;
endmodule

// File: rtl/rtc_seconds_trim_chk.sv
module rtc_seconds_trim_chk #(
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned TRIM_W  = 16,
    parameter int unsigned N_MATCH = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_en,
    input logic               rtc_en,
    input logic               load_we,
    input logic [CNT_W-1:0]   load_val,
    input logic               trim_we,
    input logic [TRIM_W-1:0]  trim_val,
    input logic [N_MATCH-1:0] flag_clr,
    input logic [CNT_W-1:0]   seconds_o,
    input logic [TRIM_W-1:0]  trim_o,
    input logic [N_MATCH-1:0] match_flag_o,
    input logic               sec_tick_o
);
    AST_GATED_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_en |-> !sec_tick_o);                                          // R1

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_en && !load_we) |=> $stable(seconds_o));                     // R5

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |-> rtc_en);                                            // R5

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick_o |=> seconds_o == CNT_W'($past(seconds_o) + 1'b1));      // R7

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> seconds_o == $past(load_val));                         // R6

    AST_TRIM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        trim_we |=> trim_o == $past(trim_val));                            // R4

    for (genvar gi = 0; gi < N_MATCH; gi++) begin : g_flag
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(match_flag_o[gi]) |-> $past(flag_clr[gi]));              // R8
    end
endmodule

bind rtc_seconds_trim rtc_seconds_trim_chk #(
    .CNT_W   (CNT_W),
    .TRIM_W  (TRIM_W),
    .N_MATCH (N_MATCH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_en       (ref_en),
    .rtc_en       (rtc_en),
    .load_we      (load_we),
    .load_val     (load_val),
    .trim_we      (trim_we),
    .trim_val     (trim_val),
    .flag_clr     (flag_clr),
    .seconds_o    (seconds_o),
    .trim_o       (trim_o),
    .match_flag_o (match_flag_o),
    .sec_tick_o   (sec_tick_o)
);

// File: tb/tb_rtc_seconds_trim.sv
module tb_rtc_seconds_trim;
    localparam int unsigned CW   = 32;
    localparam int unsigned TW   = 16;
    localparam logic [15:0] NOM  = 16'd7;   // 8 reference ticks per nominal second
    localparam int unsigned FDIV = 4;

    typedef struct packed {
        logic        slow;
        logic [15:0] trim;
        logic [15:0] cycles;   // expected cycles for 64 seconds after a load
    } vec_t;

    // 63 nominal seconds of 8 ticks plus one trimmed second of trim+1 ticks
    localparam vec_t VECS [5] = '{
        '{1'b1, 16'd7,  16'd512},
        '{1'b1, 16'd3,  16'd508},
        '{1'b1, 16'd12, 16'd517},
        '{1'b0, 16'd7,  16'd2048},
        '{1'b0, 16'd2,  16'd2028}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          osc_tick = 1'b0, ref_en = 1'b0, slow_sel = 1'b1, rtc_en = 1'b0;
    logic          load_we = 1'b0, trim_we = 1'b0;
    logic [CW-1:0] load_val = '0, match_val = '0;
    logic [TW-1:0] trim_val = '0;
    logic [1:0]    match_we = '0, flag_clr = '0;
    logic [CW-1:0] seconds_o;
    logic [TW-1:0] trim_o;
    logic [1:0]    match_flag_o;
    logic          sec_tick_o;

    int n_checks = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rtc_seconds_trim #(
        .CNT_W(CW), .TRIM_W(TW), .NOMINAL(NOM), .FAST_DIV(FDIV),
        .PERIOD_LOG2(6), .N_MATCH(2)
    ) dut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [CW-1:0] v);
        @(negedge clk); load_we = 1'b1; load_val = v;
        @(negedge clk); load_we = 1'b0;
    endtask

    task automatic do_trim(input logic [TW-1:0] v);
        @(negedge clk); trim_we = 1'b1; trim_val = v;
        @(negedge clk); trim_we = 1'b0;
    endtask

    task automatic do_match(input int idx, input logic [CW-1:0] v);
        @(negedge clk); match_we = 2'b00; match_we[idx] = 1'b1; match_val = v;
        @(negedge clk); match_we = 2'b00;
    endtask

    task automatic do_clear(input logic [1:0] m);
        @(negedge clk); flag_clr = m;
        @(negedge clk); flag_clr = 2'b00;
    endtask

    // counts rising edges until seconds_o equals target (sampled at negedges)
    task automatic run_until(input logic [CW-1:0] target, input int cap, output int n);
        n = 0;
        while (seconds_o !== target && n < cap) begin
            @(posedge clk); n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int n;
        logic [CW-1:0] held;
        int ticks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check("R5 reset seconds", seconds_o, 32'd0);
        check("R4 reset trim", 32'(trim_o), 32'(NOM));
        check("R8 reset flags", 32'(match_flag_o), 32'd0);

        // R4 schedule from reset: 63 nominal seconds, then the trimmed one
        do_trim(16'd3);
        check("R4 trim readback", 32'(trim_o), 32'd3);
        ref_en = 1'b1; slow_sel = 1'b1; rtc_en = 1'b1; osc_tick = 1'b1;
        run_until(32'd1, 100, n);
        check("R3 nominal second length", n, 8);
        run_until(32'd63, 1000, n);
        check("R3 62 nominal seconds", n, 62 * 8);
        run_until(32'd64, 100, n);
        check("R4 trimmed 64th second", n, 4);
        run_until(32'd65, 100, n);
        check("R4 schedule wraps to nominal", n, 8);

        // vector table: R2, R4, R6 over a full 64-second window
        foreach (VECS[i]) begin
            do_trim(VECS[i].trim);
            slow_sel = VECS[i].slow;
            do_load(32'(1000 * (i + 1)));
            run_until(32'(1000 * (i + 1) + 64), 5000, n);
            check($sformatf("R2/R4 vector %0d window cycles", i), n, 32'(VECS[i].cycles));
        end
        slow_sel = 1'b1;
        do_trim(NOM);

        // R6: load restarts predivider; next step one full second later
        repeat (3) @(negedge clk);
        do_load(32'd500);
        check("R6 load value", seconds_o, 32'd500);
        run_until(32'd501, 100, n);
        check("R6 full second after load", n, 8);

        // R1: gated reference stops everything
        ref_en = 1'b0; held = seconds_o; ticks = 0;
        repeat (40) begin @(posedge clk); @(negedge clk); ticks += int'(sec_tick_o); end
        check("R1 gated hold", seconds_o, held);
        check("R1 gated no tick", ticks, 0);
        ref_en = 1'b1;

        // R5: run enable low freezes the counter
        rtc_en = 1'b0; held = seconds_o;
        repeat (40) @(negedge clk);
        check("R5 disabled hold", seconds_o, held);
        rtc_en = 1'b1;

        // R7 wrap
        do_load(32'hFFFF_FFFF);
        run_until(32'd0, 100, n);
        check("R7 wrap time", n, 8);
        check("R7 wrap value", seconds_o, 32'd0);

        // wrap hit the reset-zero match registers: both flags set
        check("R8 flags after wrap to match 0", 32'(match_flag_o), 32'd3);
        do_clear(2'b11);
        check("R8 clear both", 32'(match_flag_o), 32'd0);

        // R8/R9 independent match registers
        do_match(0, 32'd2002);
        do_match(1, 32'd2004);
        do_load(32'd2000);
        run_until(32'd2002, 100, n);
        check("R9 match0 only", 32'(match_flag_o), 32'd1);
        run_until(32'd2004, 100, n);
        check("R9 both matched", 32'(match_flag_o), 32'd3);
        do_clear(2'b01);
        check("R8 clear bit0 only", 32'(match_flag_o), 32'd2);
        run_until(32'd2006, 100, n);
        check("R8 sticky flag1", 32'(match_flag_o), 32'd2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule